// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO Controller

This block carves one storage array into up to eight logical FIFO queues, each with its own base address, depth and flag thresholds. A single write port and a single read port carry data plus a queue-select index; write data is steered into the chosen queue, and read data is fetched from the chosen queue. The two selects are independent, so one cycle can write one queue while reading another, or write and read the same one.

A two-state controller governs setup. After master reset it sits in `ST_CFG`, where the layout registers may be loaded and all data traffic is refused. A pulse on `cfg_go` moves it to `ST_RUN` (transition CFG_TO_RUN), capturing the number of active queues. `ST_RUN` holds until the next master reset (transition RUN_HOLD); reset always returns to `ST_CFG`. The selected write queue reports full, the selected read queue reports output-valid, and two per-queue vectors report almost-full and almost-empty for every queue at once. A partial reset empties one queue when both ports select it.

Top module: `mq_flow_ctrl`

## Requirements
- R1: After master reset the block is in the setup state with default layout: queue q has base q*8, depth 8, almost-full offset 2 and almost-empty offset 2, all queues empty; in the setup state writes and reads are refused.
- R2: A layout write (`cfg_en`) to queue `cfg_q` is taken only in the setup state and empties that queue; `cfg_go` enters the run state and latches `cfg_nq`; in the run state layout writes have no effect.
- R3: A write stores `wr_data` into queue `wr_sel`; an accepted read of queue `rd_sel` puts its oldest word on `rd_data` after the next rising edge.
- R4: Each queue keeps first-in first-out order independently while the two ports address different queues in the same cycles.
- R5: `wr_full` is 1 when the queue on `wr_sel` holds depth words; `rd_valid` is 1 when the queue on `rd_sel` holds at least one word.
- R6: Bit q of `af_vec` is 1 when occupancy plus the almost-full offset is at least the depth; bit q of `ae_vec` is 1 when occupancy is at most the almost-empty offset; both are valid for every queue at once.
- R7: A write to a full queue and a read from an empty queue are ignored; an ignored read leaves `rd_data` unchanged.
- R8: A write and a read of the same non-empty, non-full queue in one cycle both take effect and leave its occupancy unchanged.
- R9: With `prst` high and `wr_sel` equal to `rd_sel` the selected queue is emptied and that cycle's write and read are ignored; with differing selects `prst` has no effect.
- R10: Queues with index at or above the latched active count refuse writes and reads.
- R11: Each queue's pointers wrap inside its own region from base to base+depth-1, leaving other regions intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| cfg_en | input | 1 | Layout write strobe |
| cfg_q | input | 3 | Queue whose layout is written |
| cfg_base | input | 6 | Region base address |
| cfg_depth | input | 7 | Queue depth in words |
| cfg_af | input | 7 | Almost-full offset |
| cfg_ae | input | 7 | Almost-empty offset |
| cfg_nq | input | 4 | Active queue count, latched on `cfg_go` |
| cfg_go | input | 1 | Leave setup, enter run |
| wr_en | input | 1 | Write request |
| wr_sel | input | 3 | Write queue select |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Read queue select |
| rd_data | output | 16 | Registered read data |
| prst | input | 1 | Partial reset request |
| wr_full | output | 1 | Selected write queue full |
| rd_valid | output | 1 | Selected read queue non-empty |
| af_vec | output | 8 | Almost-full flag per queue |
| ae_vec | output | 8 | Almost-empty flag per queue |

## Verification
A write and a read can hit the same queue in one cycle, and a partial reset can coincide with both. The bench drives same-queue write plus read on a half-full queue and expects unchanged occupancy and in-order data, and also fills a queue then issues write plus read together to confirm the write is refused while the read proceeds. Partial reset is raised alongside active writes and reads, with matching and with differing selects, and judged by the resulting flags and by whether the scoreboard expected a read word.

// File: rtl/mq_pkg.sv
package mq_pkg;
    typedef enum logic {
        ST_CFG = 1'b0,
        ST_RUN = 1'b1
    } mq_state_e;
endpackage

// File: rtl/mq_ctrl_fsm.sv
module mq_ctrl_fsm
    import mq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_go,
    output logic run_o,
    output logic cfg_open_o
);
    mq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CFG;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CFG: if (cfg_go) state_d = ST_RUN;
            ST_RUN: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_o      = 1'b0;
        cfg_open_o = 1'b0;
        unique case (state_q)
            ST_CFG: cfg_open_o = 1'b1;
            ST_RUN: run_o      = 1'b1;
        endcase
    end

    // R2: once running, only master reset leaves the run state
    a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> run_o);
endmodule

// File: rtl/mq_queue.sv
module mq_queue #(
    parameter int AW = 6,
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] depth_i,
    input  logic [CW-1:0] af_i,
    input  logic [CW-1:0] ae_i,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          afull_o,
    output logic          aempty_o
);
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [CW-1:0] d);
        return (({1'b0, p} + CW'(1)) >= d) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else if (clr_i) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (push_i) wp <= step(wp, depth_i);
            if (pop_i)  rp <= step(rp, depth_i);
            unique case ({push_i, pop_i})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign waddr_o  = base_i + wp;
    assign raddr_o  = base_i + rp;
    assign count_o  = cnt;
    assign full_o   = cnt >= depth_i;
    assign empty_o  = cnt == '0;
    assign afull_o  = ({1'b0, cnt} + {1'b0, af_i}) >= {1'b0, depth_i};
    assign aempty_o = cnt <= ae_i;

    // R7: occupancy never exceeds depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= depth_i);
    // R7: the port logic never pops an empty queue
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> cnt != '0);
    // R8: simultaneous push and pop keep occupancy
    a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !clr_i) |=> $stable(cnt));
    // R9: a clear leaves the queue empty
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt == '0);
endmodule

// File: rtl/mq_mem.sv
module mq_mem #(
    parameter int AW = 6,
    parameter int DW = 16,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/mq_flow_ctrl.sv
module mq_flow_ctrl #(
    parameter int NQ = 8,
    parameter int AW = 6,
    parameter int DW = 16,
    localparam int QW = $clog2(NQ),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [QW-1:0] cfg_q,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_depth,
    input  logic [CW-1:0] cfg_af,
    input  logic [CW-1:0] cfg_ae,
    input  logic [QW:0]   cfg_nq,
    input  logic          cfg_go,
    input  logic          wr_en,
    input  logic [QW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [QW-1:0] rd_sel,
    output logic [DW-1:0] rd_data,
    input  logic          prst,
    output logic          wr_full,
    output logic          rd_valid,
    output logic [NQ-1:0] af_vec,
    output logic [NQ-1:0] ae_vec
);
    localparam int DEF_D   = (1 << AW) / NQ;
    localparam int DEF_OFF = 2;

    logic run, cfg_open;

    mq_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_go     (cfg_go),
        .run_o      (run),
        .cfg_open_o (cfg_open)
    );

    logic [AW-1:0] base_r [NQ];
    logic [CW-1:0] dep_r  [NQ];
    logic [CW-1:0] af_r   [NQ];
    logic [CW-1:0] ae_r   [NQ];
    logic [QW:0]   qcnt_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                base_r[q] <= AW'(q * DEF_D);
                dep_r[q]  <= CW'(DEF_D);
                af_r[q]   <= CW'(DEF_OFF);
                ae_r[q]   <= CW'(DEF_OFF);
            end
            qcnt_r <= (QW+1)'(NQ);
        end else if (cfg_open) begin
            if (cfg_en) begin
                base_r[cfg_q] <= cfg_base;
                dep_r[cfg_q]  <= cfg_depth;
                af_r[cfg_q]   <= cfg_af;
                ae_r[cfg_q]   <= cfg_ae;
            end
            if (cfg_go) qcnt_r <= cfg_nq;
        end
    end

    logic [AW-1:0] wa_v [NQ];
    logic [AW-1:0] ra_v [NQ];
    logic [CW-1:0] cnt_v [NQ];
    logic [NQ-1:0] full_v, empty_v, push_v, pop_v, clr_v;

    logic clr_hit, wr_act, rd_act, wr_ok, rd_ok;
    assign clr_hit = run && prst && (wr_sel == rd_sel);
    assign wr_act  = {1'b0, wr_sel} < qcnt_r;
    assign rd_act  = {1'b0, rd_sel} < qcnt_r;
    assign wr_ok   = run && wr_en && !clr_hit && wr_act && !full_v[wr_sel];
    assign rd_ok   = run && rd_en && !clr_hit && rd_act && !empty_v[rd_sel];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign push_v[g] = wr_ok && (wr_sel == QW'(g));
        assign pop_v[g]  = rd_ok && (rd_sel == QW'(g));
        assign clr_v[g]  = (clr_hit && (wr_sel == QW'(g))) ||
                           (cfg_open && cfg_en && (cfg_q == QW'(g)));

        mq_queue #(.AW(AW)) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_i   (base_r[g]),
            .depth_i  (dep_r[g]),
            .af_i     (af_r[g]),
            .ae_i     (ae_r[g]),
            .clr_i    (clr_v[g]),
            .push_i   (push_v[g]),
            .pop_i    (pop_v[g]),
            .waddr_o  (wa_v[g]),
            .raddr_o  (ra_v[g]),
            .count_o  (cnt_v[g]),
            .full_o   (full_v[g]),
            .empty_o  (empty_v[g]),
            .afull_o  (af_vec[g]),
            .aempty_o (ae_vec[g])
        );

        // R10: a queue outside the active count never holds data in run
        a_r10_idle_queue_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (run && ((QW+1)'(g) >= qcnt_r)) |-> cnt_v[g] == '0);
    end

    mq_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .waddr (wa_v[wr_sel]),
        .wdata (wr_data),
        .re    (rd_ok),
        .raddr (ra_v[rd_sel]),
        .rdata (rd_data)
    );

    assign wr_full  = full_v[wr_sel];
    assign rd_valid = !empty_v[rd_sel];

    // R2: layout is frozen in the run state
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(qcnt_r) && $stable(dep_r[0]) && $stable(base_r[0])));
    // R7: an ignored read leaves the output word unchanged
    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> $stable(rd_data));
    // R1: nothing is pushed while in setup
    a_r1_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open |-> (push_v == '0 && pop_v == '0));
endmodule

// File: tb/mq_flow_ctrl_test.sv
module mq_flow_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 8, AW = 6, DW = 16, QW = 3, CW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_en = 0, cfg_go = 0, wr_en = 0, rd_en = 0, prst = 0;
    logic [QW-1:0] cfg_q = '0, wr_sel = '0, rd_sel = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_depth = '0, cfg_af = '0, cfg_ae = '0;
    logic [QW:0]   cfg_nq = '0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic wr_full, rd_valid;
    logic [NQ-1:0] af_vec, ae_vec;

    mq_flow_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_cnt[NQ], m_dep[NQ], m_af[NQ], m_ae[NQ];
    int m_nq;
    bit m_run;
    logic [DW-1:0] m_q[NQ][$];
    logic [DW-1:0] sb[$];
    bit fire = 0;
    string fire_req = "R3";

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        cfg_en = 0; cfg_go = 0; wr_en = 0; rd_en = 0; prst = 0;
    endtask

    task automatic op(input bit we, input int wq, input logic [DW-1:0] wd,
                      input bit re, input int rq, input bit pr, input string req);
        bit clr, wacc, racc;
        @(negedge clk);
        quiet();
        wr_en = we; wr_sel = QW'(wq); wr_data = wd;
        rd_en = re; rd_sel = QW'(rq); prst = pr;
        clr  = m_run && pr && (wq == rq);
        wacc = m_run && we && !clr && wq < m_nq && m_cnt[wq] < m_dep[wq];
        racc = m_run && re && !clr && rq < m_nq && m_cnt[rq] > 0;
        if (racc) begin
            sb.push_back(m_q[rq].pop_front());
            m_cnt[rq]--;
            fire = 1; fire_req = req;
        end
        if (wacc) begin m_q[wq].push_back(wd); m_cnt[wq]++; end
        if (clr) begin m_q[wq].delete(); m_cnt[wq] = 0; end
    endtask

    // monitor: compares each expected word after the read edge
    always @(posedge clk) begin
        #2;
        if (fire) begin
            logic [DW-1:0] e;
            fire = 0;
            e = sb.pop_front();
            check(rd_data == e, fire_req, rd_data, e);
        end
    end

    task automatic status(input int q, input string req);
        logic [NQ-1:0] eaf, eae;
        @(negedge clk);
        quiet();
        wr_sel = QW'(q); rd_sel = QW'(q);
        #1;
        for (int i = 0; i < NQ; i++) begin
            eaf[i] = (m_cnt[i] + m_af[i]) >= m_dep[i];
            eae[i] = m_cnt[i] <= m_ae[i];
        end
        check(wr_full == (m_cnt[q] >= m_dep[q]), {req, " wr_full"}, wr_full, m_cnt[q] >= m_dep[q]);
        check(rd_valid == (m_cnt[q] > 0), {req, " rd_valid"}, rd_valid, m_cnt[q] > 0);
        check(af_vec == eaf, {req, " af_vec R6"}, af_vec, eaf);
        check(ae_vec == eae, {req, " ae_vec R6"}, ae_vec, eae);
    endtask

    task automatic cfg_write(input int q, input int b, input int d, input int af, input int ae);
        @(negedge clk);
        quiet();
        cfg_en = 1; cfg_q = QW'(q); cfg_base = AW'(b);
        cfg_depth = CW'(d); cfg_af = CW'(af); cfg_ae = CW'(ae);
        if (!m_run) begin
            m_dep[q] = d; m_af[q] = af; m_ae[q] = ae;
            m_q[q].delete(); m_cnt[q] = 0;
        end
    endtask

    task automatic go(input int n);
        @(negedge clk);
        quiet();
        cfg_go = 1; cfg_nq = (QW+1)'(n);
        if (!m_run) begin m_run = 1; m_nq = n; end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] last;
        for (int i = 0; i < NQ; i++) begin
            m_cnt[i] = 0; m_dep[i] = 8; m_af[i] = 2; m_ae[i] = 2;
        end
        m_nq = NQ; m_run = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state and refusal of traffic during setup
        status(0, "R1");
        op(1, 0, 16'h1111, 0, 0, 0, "R1");
        status(0, "R1");

        // R2: layout for several queues, six active
        cfg_write(0, 0, 4, 1, 1);
        cfg_write(1, 4, 12, 3, 2);
        go(6);
        cfg_write(0, 0, 8, 2, 2);   // ignored in run
        status(0, "R2");

        // R5/R7: fill queue 0, overfill, drain
        for (int i = 0; i < 4; i++) op(1, 0, DW'(16'hA000 + i), 0, 0, 0, "R3");
        status(0, "R5");
        op(1, 0, 16'hDEAD, 0, 0, 0, "R7");
        status(0, "R7");
        // R8: write+read to a full queue: write refused, read proceeds
        op(1, 0, 16'hBEEF, 1, 0, 0, "R8");
        status(0, "R8");
        for (int i = 0; i < 3; i++) op(0, 0, 0, 1, 0, 0, "R3");
        status(0, "R5");
        last = rd_data;
        op(0, 0, 0, 1, 0, 0, "R7");
        status(0, "R7");
        check(rd_data == last, "R7 read hold", rd_data, last);

        // R4: different queues on the two ports in the same cycles
        for (int i = 0; i < 5; i++) op(1, 1, DW'(16'hB100 + i), 0, 0, 0, "R4");
        for (int i = 0; i < 5; i++) op(1, 2, DW'(16'hC200 + i), 1, 1, 0, "R4");
        status(1, "R4");
        status(2, "R4");

        // R8: same queue written and read in one cycle
        for (int i = 0; i < 4; i++) op(1, 2, DW'(16'hD300 + i), 1, 2, 0, "R8");
        status(2, "R8");

        // R11: wrap queue 0 many times while queue 1 holds data
        op(1, 1, 16'hE000, 0, 0, 0, "R11");
        for (int i = 0; i < 10; i++) begin
            op(1, 0, DW'(16'hF000 + i), 0, 0, 0, "R11");
            op(0, 0, 0, 1, 0, 0, "R11");
        end
        while (m_cnt[1] > 0) op(0, 0, 0, 1, 1, 0, "R11");
        status(1, "R11");

        // R9: partial reset with differing selects, then matching
        op(1, 3, 16'h3333, 0, 0, 0, "R9");
        op(1, 3, 16'h3334, 1, 2, 1, "R9");
        status(3, "R9");
        op(1, 2, 16'h2222, 1, 2, 1, "R9");
        status(2, "R9");
        op(0, 0, 0, 1, 3, 0, "R9");

        // R10: queues beyond the active count refuse traffic
        op(1, 6, 16'h6666, 0, 0, 0, "R10");
        status(6, "R10");
        op(0, 0, 0, 1, 6, 0, "R10");
        status(6, "R10");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
        summary();
        $finish;
    end
endmodule